// File: doc/BRIEF.md
# Block-Transfer Channel Slot Sequencer

This block orders the bus cycles of a four-channel block-transfer engine. Three channels (A, B, C) read source words and one channel (D) writes destination words. A write to the size register starts a transfer. From then on, the sequencer spends each bus slot that an outside arbiter grants on exactly one micro-operation. A micro-operation is one of three things: a source fetch, a hold step that leaves the bus unused, or a destination write. The micro-operation list is chosen from the channel-enable pattern captured at the start.

Each fetched source word sits in a hold stage for one iteration before it is used. Because of this, the destination write for word n falls in the iteration that fetches word n+1, and a single flush slot writes the final word. The busy flag drops at the moment the flush begins. A done pulse and an interrupt request mark the flush slot.

Data processing, shifting and masking are outside this block. Each channel's address is a plain counter that restarts at zero with every transfer.

Top module: `blit_slot_seq`

## Requirements
- R1: A size write while the sequencer is idle starts a transfer. `busy` is high from the next cycle, and the channel enables (`chan_en` bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) are captured at that write.
- R2: Every granted slot during a transfer carries exactly one micro-operation, shown by `op_valid`. `op_valid` is never high without `slot_grant`, and a cycle without a grant does not advance the sequence.
- R3: Within each word iteration, the enabled sources are fetched in the order A, B, C (`op_code` 1, 2, 3), followed by the D slot when D is enabled.
- R4: In the first iteration the D slot is a hold step (`op_code` 0, `op_addr` 0), because no word has been fetched yet.
- R5: The D slot of iteration n writes word n-1 (`op_code` 4, `op_addr` n-1), and the flush slot writes the last word. Source addresses run 0 to N-1, one per iteration.
- R6: `size_data[15:6]` holds the height in rows and `size_data[5:0]` holds the width in words. A zero field means 1024 rows or 64 words. The transfer covers width times height words.
- R7: `busy` goes low in the cycle after the last loop slot is granted, which is when the flush begins. It stays low while the flush slot waits for a grant.
- R8: With every channel disabled, each word takes one hold slot and the flush is one hold slot. The transfer still ends and `busy` still clears.
- R9: `done` and `irq` are high for exactly the one cycle in which the flush slot is granted.
- R10: A size write is ignored while `busy` is high and while the flush slot waits without a grant. A size write in the same cycle that the flush slot is granted starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_wr | input | 1 | Write strobe for the size register |
| size_data | input | 16 | Height (upper 10 bits) and width in words (lower 6 bits) |
| chan_en | input | 4 | Channel enables: bit 0 A, bit 1 B, bit 2 C, bit 3 D |
| slot_grant | input | 1 | The current bus slot is free for this block |
| busy | output | 1 | Transfer in progress, cleared when the flush begins |
| op_valid | output | 1 | A micro-operation uses the current granted slot |
| op_code | output | 3 | 0 hold, 1 fetch A, 2 fetch B, 3 fetch C, 4 write D |
| op_addr | output | 16 | Word index of the channel being accessed (0 for hold) |
| done | output | 1 | One-cycle pulse on the granted flush slot |
| irq | output | 1 | Completion interrupt request, raised with `done` |

## Verification
The completion of the flush slot and the start of a new transfer can land in the same cycle. This happens when software sees `busy` low and writes the size register just as the arbiter grants the flush slot. The bench provokes this by driving the write and the grant together. In that cycle it checks that `done` and `irq` pulse and that the last D write carries the correct address. In the following cycle it checks that `busy` is high again and that the new transfer's first fetch uses address 0. A size write made while the flush slot is still waiting for a grant is checked separately, to confirm that it is dropped.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;
  localparam int NCH = 4;
  localparam int PW  = 2;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_FA   = 3'd1,
    OP_FB   = 3'd2,
    OP_FC   = 3'd3,
    OP_WD   = 3'd4
  } uop_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} seq_st_e;

  // A zero size field stands for the largest count the field can hold plus one.
  function automatic int dim_decode(input int field, input int bits);
    return (field == 0) ? (1 << bits) : field;
  endfunction

  // Slots per word iteration: one per enabled channel, at least one.
  function automatic int group_len(input logic [NCH-1:0] en);
    int n;
    n = 0;
    for (int k = 0; k < NCH; k++) n += int'(en[k]);
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/blit_uop_sel.sv
module blit_uop_sel
  import blit_seq_pkg::*;
(
  input  logic [NCH-1:0] cfg,
  input  logic [PW-1:0]  pos,
  input  logic           first_word,
  output uop_e           op,
  output logic           last_pos
);
  always_comb begin
    int seen;
    seen = 0;
    op   = OP_HOLD;
    for (int k = 0; k < NCH; k++) begin
      if (cfg[k]) begin
        if (seen == int'(pos)) begin
          if (k == NCH - 1) op = first_word ? OP_HOLD : OP_WD;
          else              op = uop_e'(3'(k + 1));
        end
        seen++;
      end
    end
    last_pos = (int'(pos) == group_len(cfg) - 1);
  end
endmodule

// File: rtl/blit_word_ctr.sv
module blit_word_ctr
  import blit_seq_pkg::*;
#(
  parameter int WBITS = 6,
  parameter int HBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WBITS-1:0] w_field,
  input  logic [HBITS-1:0] h_field,
  input  logic             step,
  output logic             first_word,
  output logic             last_word
);
  localparam int CW = WBITS + 1;
  localparam int CH = HBITS + 1;

  logic [CW-1:0] width_q, col_q;
  logic [CH-1:0] height_q, row_q;
  logic          col_end;

  assign col_end    = (col_q == width_q - CW'(1));
  assign first_word = (col_q == '0) && (row_q == '0);
  assign last_word  = col_end && (row_q == height_q - CH'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= CW'(1);
      height_q <= CH'(1);
      col_q    <= '0;
      row_q    <= '0;
    end else if (load) begin
      width_q  <= CW'(dim_decode(int'(w_field), WBITS));
      height_q <= CH'(dim_decode(int'(h_field), HBITS));
      col_q    <= '0;
      row_q    <= '0;
    end else if (step) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_q + CH'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/blit_chan_ptrs.sv
module blit_chan_ptrs
  import blit_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          exec,
  input  uop_e          op,
  output logic [AW-1:0] addr
);
  for (genvar g = 0; g < NCH; g++) begin : g_ptr
    localparam uop_e MY_OP = (g == NCH - 1) ? OP_WD : uop_e'(3'(g + 1));
    logic [AW-1:0] ptr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ptr <= '0;
      else if (clear)                  ptr <= '0;
      else if (exec && op == MY_OP)    ptr <= ptr + AW'(1);
    end
  end

  always_comb begin
    case (op)
      OP_FA:   addr = g_ptr[0].ptr;
      OP_FB:   addr = g_ptr[1].ptr;
      OP_FC:   addr = g_ptr[2].ptr;
      OP_WD:   addr = g_ptr[3].ptr;
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
  import blit_seq_pkg::*;
#(
  parameter int WBITS = 6,
  parameter int HBITS = 10,
  parameter int AW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   size_wr,
  input  logic [WBITS+HBITS-1:0] size_data,
  input  logic [NCH-1:0]         chan_en,
  input  logic                   slot_grant,
  output logic                   busy,
  output logic                   op_valid,
  output logic [2:0]             op_code,
  output logic [AW-1:0]          op_addr,
  output logic                   done,
  output logic                   irq
);
  seq_st_e        state_q;
  logic [NCH-1:0] cfg_q;
  logic [PW-1:0]  pos_q;
  logic           busy_q;

  uop_e rom_op, cur_op;
  logic rom_last, first_word, last_word;

  // Named events, also observed by the bound checker.
  logic start_evt, exec_run, exec_flush, loop_wrap, enter_flush;

  assign exec_run    = (state_q == ST_RUN) && slot_grant;
  assign exec_flush  = (state_q == ST_FLUSH) && slot_grant;
  assign start_evt   = size_wr && ((state_q == ST_IDLE) || exec_flush);
  assign loop_wrap   = exec_run && rom_last;
  assign enter_flush = loop_wrap && last_word;

  blit_uop_sel u_sel (
    .cfg        (cfg_q),
    .pos        (pos_q),
    .first_word (first_word),
    .op         (rom_op),
    .last_pos   (rom_last)
  );

  blit_word_ctr #(.WBITS(WBITS), .HBITS(HBITS)) u_words (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_evt),
    .w_field    (size_data[WBITS-1:0]),
    .h_field    (size_data[WBITS+HBITS-1:WBITS]),
    .step       (loop_wrap),
    .first_word (first_word),
    .last_word  (last_word)
  );

  always_comb begin
    if (exec_run)        cur_op = rom_op;
    else if (exec_flush) cur_op = cfg_q[NCH-1] ? OP_WD : OP_HOLD;
    else                 cur_op = OP_HOLD;
  end

  blit_chan_ptrs #(.AW(AW)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_evt),
    .exec  (op_valid),
    .op    (cur_op),
    .addr  (op_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      pos_q   <= '0;
      busy_q  <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_RUN;
      cfg_q   <= chan_en;
      pos_q   <= '0;
      busy_q  <= 1'b1;
    end else if (exec_run) begin
      if (rom_last) begin
        pos_q <= '0;
        if (last_word) begin
          state_q <= ST_FLUSH;
          busy_q  <= 1'b0;
        end
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end else if (exec_flush) begin
      state_q <= ST_IDLE;
    end
  end

  assign busy     = busy_q;
  assign op_valid = exec_run || exec_flush;
  assign op_code  = cur_op;
  assign done     = exec_flush;
  assign irq      = exec_flush;
endmodule

// File: rtl/blit_slot_seq_chk.sv
module blit_slot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic size_wr,
  input logic slot_grant,
  input logic busy,
  input logic op_valid,
  input logic done,
  input logic irq,
  input logic start_evt,
  input logic enter_flush
);
  assert_grant_gates_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> slot_grant);

  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_busy_clears_at_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(enter_flush));

  assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_flush_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || irq) |-> (op_valid && !busy));

  assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && size_wr) |-> !start_evt);
endmodule

bind blit_slot_seq blit_slot_seq_chk u_chk (.*);

// File: tb/tb_blit_slot_seq.sv
`timescale 1ns/1ps
module tb_blit_slot_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        size_wr = 1'b0;
  logic [15:0] size_data = '0;
  logic [3:0]  chan_en = '0;
  logic        slot_grant = 1'b0;
  logic        busy, op_valid, done, irq;
  logic [2:0]  op_code;
  logic [15:0] op_addr;

  int errors = 0, checks = 0, cyc = 0, gmode = 0;
  int slot_no = 0, poke_at = -1;
  bit finished = 0;

  always #5 clk = ~clk;

  blit_slot_seq dut (
    .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .size_data(size_data),
    .chan_en(chan_en), .slot_grant(slot_grant), .busy(busy), .op_valid(op_valid),
    .op_code(op_code), .op_addr(op_addr), .done(done), .irq(irq)
  );

  // cfg, height field, width field, grant pattern, slot index for a stray write
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{15, 1, 3, 0, -1},
    '{15, 2, 2, 1,  5},
    '{ 1, 1, 4, 0, -1},
    '{ 9, 3, 1, 2, -1},
    '{ 8, 1, 3, 1, -1},
    '{ 0, 2, 2, 0, -1},
    '{ 6, 1, 2, 2,  2},
    '{13, 1, 0, 0, -1}
  };

  function automatic bit grant_for(input int mode, input int c);
    case (mode)
      1:       return (c % 2) == 0;
      2:       return (c % 3) == 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_slot(input int eop, input int eaddr, input bit ebusy, input bit edone, input string req);
    forever begin
      @(negedge clk);
      size_wr = 1'b0;
      slot_grant = grant_for(gmode, cyc);
      cyc++;
      if (slot_no == poke_at) begin
        size_wr = 1'b1; size_data = {10'd1, 6'd1}; chan_en = 4'b0100; poke_at = -1;
      end
      #1;
      if (!slot_grant) begin
        chk(op_valid == 1'b0, "R2", "op_valid without grant", int'(op_valid), 0);
      end else begin
        chk(op_valid == 1'b1, req, "op_valid", int'(op_valid), 1);
        chk(int'(op_code) == eop, req, "op_code", int'(op_code), eop);
        chk(int'(op_addr) == eaddr, req, "op_addr", int'(op_addr), eaddr);
        chk(busy == ebusy, (edone ? "R7" : req), "busy", int'(busy), int'(ebusy));
        chk(done == edone && irq == edone, "R9", "done/irq", int'(done) + 2 * int'(irq), 3 * int'(edone));
        slot_no++;
        break;
      end
    end
  endtask

  task automatic start_blit(input int cfg, input int h, input int w);
    @(negedge clk);
    size_wr = 1'b1; size_data = {h[9:0], w[5:0]}; chan_en = cfg[3:0]; slot_grant = 1'b0;
    cyc++; slot_no = 0;
  endtask

  task automatic loop_slots(input int cfg, input int n);
    for (int i = 0; i < n; i++) begin
      if (cfg == 0) expect_slot(0, 0, 1, 0, "R8");
      for (int k = 0; k < 3; k++) if (cfg[k]) expect_slot(k + 1, i, 1, 0, "R3");
      if (cfg[3]) begin
        if (i == 0) expect_slot(0, 0, 1, 0, "R4");
        else        expect_slot(4, i - 1, 1, 0, "R5");
      end
    end
  endtask

  task automatic flush_slot(input int cfg, input int n);
    expect_slot(cfg[3] ? 4 : 0, cfg[3] ? n - 1 : 0, 0, 1, "R5");
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    size_wr = 1'b0; slot_grant = 1'b1; cyc++;
    #1;
    chk(busy == 1'b0, req, "busy when idle", int'(busy), 0);
    chk(op_valid == 1'b0, req, "op_valid when idle", int'(op_valid), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && op_valid == 0 && done == 0 && irq == 0, "reset", "outputs in reset",
        int'(busy) + int'(op_valid) + int'(done) + int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of configurations and grant patterns.
    for (int v = 0; v < NV; v++) begin
      gmode = VEC[v][3];
      n = (VEC[v][1] == 0 ? 1024 : VEC[v][1]) * (VEC[v][2] == 0 ? 64 : VEC[v][2]);
      start_blit(VEC[v][0], VEC[v][1], VEC[v][2]);
      poke_at = VEC[v][4];       // R10: stray size write during the run
      loop_slots(VEC[v][0], n);
      flush_slot(VEC[v][0], n);
      check_idle("R10");
    end

    // R1: busy rises after the start write, nothing runs without a grant.
    gmode = 0;
    start_blit(15, 1, 1);
    @(negedge clk);
    size_wr = 1'b0; slot_grant = 1'b0; cyc++;
    #1;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    chk(op_valid == 1'b0, "R2", "op_valid without grant", int'(op_valid), 0);
    loop_slots(15, 1);
    flush_slot(15, 1);
    check_idle("R8");

    // R6: zero height field means 1024 rows.
    start_blit(1, 0, 1);
    loop_slots(1, 1024);
    flush_slot(1, 1024);
    chk(slot_no == 1025, "R6", "slots for 1024x1", slot_no, 1025);

    // R8: everything disabled, 64-word width from zero field.
    start_blit(0, 1, 0);
    loop_slots(0, 64);
    flush_slot(0, 64);
    chk(slot_no == 65, "R8", "slots with no channels", slot_no, 65);
    check_idle("R8");

    // R10: write while flush waits is dropped.
    start_blit(1, 1, 1);
    loop_slots(1, 1);
    @(negedge clk);
    slot_grant = 1'b0; size_wr = 1'b1; size_data = {10'd1, 6'd1}; chan_en = 4'b1111; cyc++;
    #1;
    chk(busy == 1'b0, "R7", "busy during flush wait", int'(busy), 0);
    chk(op_valid == 1'b0, "R10", "op_valid during flush wait", int'(op_valid), 0);
    flush_slot(1, 1);
    check_idle("R10");

    // R10: write in the cycle the flush slot is granted starts a new transfer.
    start_blit(9, 1, 2);
    loop_slots(9, 2);
    @(negedge clk);
    slot_grant = 1'b1; size_wr = 1'b1; size_data = {10'd1, 6'd1}; chan_en = 4'b0001; cyc++;
    #1;
    chk(done == 1'b1 && irq == 1'b1, "R10", "done on colliding flush", int'(done), 1);
    chk(int'(op_code) == 4 && int'(op_addr) == 1, "R10", "flush write address", int'(op_addr), 1);
    slot_no = 0;
    expect_slot(1, 0, 1, 0, "R10");
    flush_slot(1, 1);
    check_idle("R10");

    finish_run();
  end
endmodule